// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Per-Channel Prescalers

This block generates two independent pulse-width-modulated outputs. A host programs them through a small register bus that is 32 bits wide and addressed by word. Each channel has a duty word with two fields: the number of divided clock ticks the output stays high, and the number it stays low. A shared control word holds three settings for each channel: a 7-bit divider, a clock-enable bit and an output-enable bit. A channel runs only when both of its enable bits are set. While running, it divides the input clock by its divider value plus one. Each period begins with the high phase and then moves to the low phase, and this repeats.

Each channel is a state machine with three states: CH_IDLE, CH_HIGH and CH_LOW. The transitions are:
- START (CH_IDLE to CH_HIGH or CH_LOW): taken once both enable bits are set. The channel captures the duty and divider settings, and the high count chooses the first state.
- PHASE_SWITCH (CH_HIGH to CH_LOW): taken when the high count expires and the low count is nonzero.
- RELOAD (CH_HIGH or CH_LOW to CH_HIGH or CH_LOW): taken at the period boundary. The channel recaptures its settings here.
- STOP (any state to CH_IDLE): taken when either enable bit is clear. It clears the prescaler and the phase counter.

Settings are captured only at START and RELOAD. A register write therefore never shortens or glitches a phase that is already in progress.

Top module: `dual_pwm`

## Requirements
- R1: Word 0 is channel A's duty register, word 1 is channel B's duty register and word 2 is the control register. A word reads back the value last written to it. Word 3 reads as zero, and a write to word 3 changes no register.
- R2: In a duty word, bits 31:16 hold the high count and bits 15:0 hold the low count. Both counts are in divided clock ticks.
- R3: In the control word:
  - Channel A uses bits 14:8 for its divider, bit 15 for its clock enable and bit 0 for its output enable.
  - Channel B uses bits 22:16 for its divider, bit 23 for its clock enable and bit 1 for its output enable.
  - All other bits read as zero.
- R4: A channel with divider field D holds its output high for (high count)×(D+1) clock cycles and low for (low count)×(D+1) clock cycles.
- R5: Each period starts with the high phase, which is followed by the low phase.
- R6: When either enable bit of a channel is clear, the channel's output is low.
- R7: When a control write makes a channel run with a nonzero high count, the output is high starting one clock edge after the edge that accepts the write.
- R8: A duty write made during a period changes neither the current high phase nor the current low phase. The new values apply from the next period.
- R9: A high count of zero gives a constant low output.
- R10: A low count of zero and a nonzero high count give a constant high output.
- R11: The two channels run independently of each other, each with its own settings.
- R12: After reset, all registers read as zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word selected by bus_addr |
| pwm_out | output | 2 | PWM outputs, bit 0 is channel A and bit 1 is channel B |

## Verification
A wrong phase counter or a wrong prescaler count shows up as a wrong pulse length within one period. The error is a multiple of (D+1) cycles, so the bench measures each high and low run in exact clock cycles. A settings capture taken at the wrong moment shows up as a shortened or lengthened pulse in the period that contains the duty write. A missing return to CH_IDLE shows up as an output that stays high after an enable bit is cleared, on the next clock edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PWM_DATA_W = 32;
    localparam int PWM_CNT_W  = 16;
    localparam int PWM_DIV_W  = 7;
    localparam int PWM_NUM_CH = 2;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int NUM_CH = pwm_pkg::PWM_NUM_CH,
    parameter int DATA_W = pwm_pkg::PWM_DATA_W,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = pwm_pkg::PWM_CNT_W,
    parameter int DIV_W  = pwm_pkg::PWM_DIV_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_CH-1:0][CNT_W-1:0]  hi_cnt,
    output logic [NUM_CH-1:0][CNT_W-1:0]  lo_cnt,
    output logic [NUM_CH-1:0][DIV_W-1:0]  div_val,
    output logic [NUM_CH-1:0]             clk_en,
    output logic [NUM_CH-1:0]             out_en
);
    localparam int FLD_W = DIV_W + 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NUM_CH);

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            m[i] = 1'b1;
            m[FLD_W*(i+1) +: FLD_W] = '1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

    logic [NUM_CH-1:0][DATA_W-1:0] duty_q;
    logic [DATA_W-1:0]             ctrl_q;
    logic                          wr_en;

    assign wr_en = sel && wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(i)) duty_q[i] <= wdata;
            end
            if (addr == CTRL_A) ctrl_q <= wdata & CTRL_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rdata = duty_q[i];
        end
        if (addr == CTRL_A) rdata = ctrl_q;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_fields
        assign hi_cnt[g]  = duty_q[g][DATA_W-1 -: CNT_W];
        assign lo_cnt[g]  = duty_q[g][CNT_W-1:0];
        assign div_val[g] = ctrl_q[FLD_W*(g+1) +: DIV_W];
        assign clk_en[g]  = ctrl_q[FLD_W*(g+1) + DIV_W];
        assign out_en[g]  = ctrl_q[g];

        // R2
        duty_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(g)) |=> (hi_cnt[g] == $past(wdata[DATA_W-1 -: CNT_W])
                                               && lo_cnt[g] == $past(wdata[CNT_W-1:0])));
    end

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == CTRL_A) |=> $stable(ctrl_q));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DIV_W = pwm_pkg::PWM_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = !clr && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // R4
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> cnt_q <= div);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = PWM_CNT_W,
    parameter int DIV_W = PWM_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    input  logic [DIV_W-1:0] div_in,
    output logic             pwm_out
);
    ch_state_e        state_q, state_n;
    logic [CNT_W-1:0] hi_s, lo_s, cnt_q, cnt_n;
    logic [DIV_W-1:0] div_s;
    logic             load, tick, presc_clr;

    assign presc_clr = !run || (state_q == CH_IDLE);

    pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (presc_clr),
        .div  (div_s),
        .tick (tick)
    );

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        load    = 1'b0;
        unique case (state_q)
            CH_IDLE: if (run) load = 1'b1;
            CH_HIGH: if (tick) begin
                if (cnt_q == hi_s - 1'b1) begin
                    if (lo_s != '0) begin
                        state_n = CH_LOW;
                        cnt_n   = '0;
                    end else begin
                        load = 1'b1;
                    end
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            CH_LOW: if (tick) begin
                if (lo_s == '0 || cnt_q == lo_s - 1'b1) load = 1'b1;
                else                                    cnt_n = cnt_q + 1'b1;
            end
            default: state_n = CH_IDLE;
        endcase
        if (load) begin
            state_n = (hi_in != '0) ? CH_HIGH : CH_LOW;
            cnt_n   = '0;
        end
        if (!run) begin
            state_n = CH_IDLE;
            cnt_n   = '0;
            load    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            hi_s    <= '0;
            lo_s    <= '0;
            div_s   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            if (load) begin
                hi_s  <= hi_in;
                lo_s  <= lo_in;
                div_s <= div_in;
            end
        end
    end

    always_comb pwm_out = (state_q == CH_HIGH);

    // R6
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm_out);
    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && run && !tick) |=> ($stable(hi_s) && $stable(lo_s) && $stable(div_s)));
    // R4
    high_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HIGH) |-> (cnt_q < hi_s));
    // R7
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && run && hi_in != '0) |=> pwm_out);
endmodule

// File: rtl/dual_pwm.sv
module dual_pwm
    import pwm_pkg::*;
#(
    parameter int NUM_CH = PWM_NUM_CH,
    parameter int DATA_W = PWM_DATA_W,
    parameter int CNT_W  = PWM_CNT_W,
    parameter int DIV_W  = PWM_DIV_W,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0][CNT_W-1:0] hi_cnt, lo_cnt;
    logic [NUM_CH-1:0][DIV_W-1:0] div_val;
    logic [NUM_CH-1:0]            clk_en, out_en;

    pwm_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .DIV_W(DIV_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .hi_cnt (hi_cnt),
        .lo_cnt (lo_cnt),
        .div_val(div_val),
        .clk_en (clk_en),
        .out_en (out_en)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (clk_en[g] & out_en[g]),
            .hi_in  (hi_cnt[g]),
            .lo_in  (lo_cnt[g]),
            .div_in (div_val[g]),
            .pwm_out(pwm_out[g])
        );
    end
endmodule

// File: tb/tb_dual_pwm.sv
module tb_dual_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0, n_fail = 0;
    int unsigned seed_v;

    dual_pwm dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    function automatic int exp_len(int cnt, int d);
        return cnt * (d + 1);
    endfunction

    function automatic logic [31:0] ctrl_word(int ch, int d);
        logic [31:0] w;
        w = '0;
        w[ch] = 1'b1;
        w[8*(ch+1) +: 8] = {1'b1, 7'(d)};
        return w;
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // length of the next complete high run and following low run
    task automatic measure(int ch, output int hl, output int ll);
        int guard;
        hl = 0; ll = 0; guard = 0;
        @(negedge clk);
        while (pwm_out[ch] && guard < 5000) begin guard++; @(negedge clk); end
        while (!pwm_out[ch] && guard < 5000) begin guard++; @(negedge clk); end
        while (pwm_out[ch] && hl < 5000) begin hl++; @(negedge clk); end
        while (!pwm_out[ch] && ll < 5000) begin ll++; @(negedge clk); end
    endtask

    task automatic count_high(int ch, int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) highs++;
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int hl, ll, c, hs;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 out", pwm_out, 0);
        reg_rd(2'd0, rd); check("R12 word0", rd, 0);
        reg_rd(2'd2, rd); check("R12 word2", rd, 0);
        rst_n = 1'b1;

        // R3 control mask readback
        reg_wr(2'd2, 32'hFFFF_FFFF);
        reg_rd(2'd2, rd); check("R3 ctrl readback", rd, 32'h00FF_FF03);
        reg_wr(2'd2, 32'h0);
        // R1 map and word 3
        reg_wr(2'd0, 32'h1234_5678);
        reg_wr(2'd1, 32'h9ABC_DEF0);
        reg_wr(2'd3, 32'hFFFF_FFFF);
        reg_rd(2'd3, rd); check("R1 word3", rd, 0);
        reg_rd(2'd0, rd); check("R1 word0", rd, 32'h1234_5678);
        reg_rd(2'd1, rd); check("R1 word1", rd, 32'h9ABC_DEF0);
        reg_rd(2'd2, rd); check("R1 word2 untouched", rd, 0);

        // R2 field order, R7 start latency, R5 high first
        reg_wr(2'd0, 32'h0003_0005);
        reg_wr(2'd2, ctrl_word(0, 0));
        @(negedge clk); check("R7 high after enable", pwm_out[0], 1);
        measure(0, hl, ll);
        check("R2 high", hl, 3); check("R2 low", ll, 5);

        // R6 only one enable bit set
        reg_wr(2'd2, 32'h0000_8000);
        count_high(0, 60, hs); check("R6 clk_en only", hs, 0);
        reg_wr(2'd2, 32'h0000_0001);
        count_high(0, 60, hs); check("R6 out_en only", hs, 0);
        reg_wr(2'd2, 32'h0);

        // R8 duty write mid-period
        reg_wr(2'd0, 32'h0004_0004);
        reg_wr(2'd2, ctrl_word(0, 0));
        @(negedge clk);
        while (pwm_out[0]) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        reg_wr(2'd0, 32'h000A_0004);
        c = 2;
        while (pwm_out[0] && c < 100) begin c++; @(negedge clk); end
        check("R8 current high kept", c, 4);
        c = 0;
        while (!pwm_out[0] && c < 100) begin c++; @(negedge clk); end
        check("R8 current low kept", c, 4);
        c = 0;
        while (pwm_out[0] && c < 100) begin c++; @(negedge clk); end
        check("R8 next high new", c, 10);
        reg_wr(2'd2, 32'h0);
        @(negedge clk); check("R6 disable low", pwm_out[0], 0);

        // R9 zero high count
        reg_wr(2'd1, 32'h0000_0005);
        reg_wr(2'd2, ctrl_word(1, 1));
        count_high(1, 150, hs); check("R9 constant low", hs, 0);
        // R10 zero low count
        reg_wr(2'd1, 32'h0005_0000);
        reg_wr(2'd2, 32'h0);
        reg_wr(2'd2, ctrl_word(1, 1));
        count_high(1, 150, hs); check("R10 constant high", hs, 150);
        reg_wr(2'd2, 32'h0);

        // R11 both channels together
        reg_wr(2'd0, 32'h0003_0005);
        reg_wr(2'd1, 32'h0007_0002);
        reg_wr(2'd2, ctrl_word(0, 1) | ctrl_word(1, 2));
        measure(0, hl, ll);
        check("R11 A high", hl, exp_len(3, 1)); check("R11 A low", ll, exp_len(5, 1));
        measure(1, hl, ll);
        check("R11 B high", hl, exp_len(7, 2)); check("R11 B low", ll, exp_len(2, 2));
        reg_wr(2'd2, 32'h0);

        // R4 random divider and counts
        for (int it = 0; it < 12; it++) begin
            int ch, h, l, d;
            ch = $urandom % 2;
            h  = 1 + $urandom % 12;
            l  = 1 + $urandom % 12;
            d  = $urandom % 5;
            if (it == 11) d = 127;
            reg_wr(2'd2, 32'h0);
            reg_wr(2'(ch), {16'(h), 16'(l)});
            reg_wr(2'd2, ctrl_word(ch, d));
            measure(ch, hl, ll);
            check("R4 high len", hl, exp_len(h, d));
            check("R4 low len", ll, exp_len(l, d));
        end
        reg_wr(2'd2, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule